// File: doc/BRIEF.md
# Batched Descriptor Reference Cache

This block sits between a DMA engine and the reference queues that live in host memory. On the receive side it keeps a small store of free-buffer references. When that store runs dry it fetches a new group with one read burst, then hands the references to the DMA engine one per pop. On the transmit side it collects the references of completed packets. When the collected group reaches the limit, it returns the whole group to host memory with one write burst. Grouping the references this way cuts the per-packet bus overhead.

A single enable input chooses between grouped operation, with groups of six, and single-reference operation, in which every reference moves in its own one-word burst. Toward the bus master there is one burst port. The cache raises a request together with a direction and a word count. The master then acknowledges one word per cycle: it returns read data on a fetch and takes write data on a write-back. Once a burst has started it runs to its last word. When both kinds of burst are waiting, the write-back is started first.

Top module: `refcache_top`

## Requirements
- R1: While reset is high, bus_req and pop_ready are 0 and push_ready is 1. In the first cycle after reset, a fetch request is raised, because the free store starts empty.
- R2: A fetch (bus_write=0) is requested only when the free store is empty. The request appears one cycle after the store empties, with bus_words = 6 in grouped mode. Each acknowledged word is stored as one free reference.
- R3: pop_ready is 1 exactly when the free store holds a reference. Each pop hands out references in the order they were fetched. A requester that sees pop_ready=0 stalls until the refill delivers.
- R4: In grouped mode, a write-back (bus_write=1) is requested one cycle after the completed store reaches 6. It has bus_words = 6, and bus_wr_data presents the pushed references in push order, advancing one per acknowledged word.
- R5: push_ready is 0 from the moment the completed store is full until the last word of the write-back has been acknowledged. It is 1 again in the following cycle.
- R6: When, in an idle cycle, a write-back and a fetch are both pending, the write-back is started first. The fetch follows one cycle after the write-back ends.
- R7: From the cycle a burst starts until its last acknowledged word, bus_req stays 1 and bus_write and bus_words stay constant. bus_req is 0 in the cycle after the last word.
- R8: With batch_en=0, every fetch and every write-back has bus_words = 1. A single pushed reference blocks further pushes until its one-word write-back completes.
- R9: Neither store ever holds more than 6 references, and both are empty after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| batch_en | input | 1 | 1 = grouped bursts of LIMIT, 0 = one reference per burst |
| pop_req | input | 1 | DMA engine takes a free reference |
| pop_ready | output | 1 | A free reference is available |
| pop_ref | output | REF_W (32) | Free reference at the head of the store |
| push_req | input | 1 | DMA engine returns a completed reference |
| push_ref | input | REF_W (32) | Completed reference |
| push_ready | output | 1 | Completed store accepts a reference |
| bus_req | output | 1 | Burst request toward the bus master |
| bus_write | output | 1 | 1 = write-back of completed refs, 0 = fetch of free refs |
| bus_words | output | CW (3) | Word count of the current burst |
| bus_ack | input | 1 | Master moves one word this cycle |
| bus_rd_data | input | REF_W (32) | Fetched word, valid with bus_ack on a fetch |
| bus_wr_data | output | REF_W (32) | Word to write back, taken with bus_ack |

## Verification
The assertions assume that the master raises bus_ack only while bus_req is 1 and never beyond the announced word count. They also assume that pop_req and push_req are qualified by the matching ready signal. The bench acts as the master and only pulses bus_ack inside a request, one word per cycle, exactly bus_words times. It also checks pop_ready and push_ready before it drives a pop or a push. batch_en is changed only in idle cycles, so each burst length is decided under a single mode.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_WBACK = 2'd2
  } bus_state_e;
endpackage

// File: rtl/rc_fifo.sv
module rc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 6,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= nxt(wp);
      if (rd_en) rp <= nxt(rp);
      if (wr_en && !rd_en)      count <= count + CW'(1);
      else if (!wr_en && rd_en) count <= count - CW'(1);
    end
  end

  assign rd_data = mem[rp];

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < CW'(DEPTH)) || rd_en);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> count != '0);
endmodule

// File: rtl/rc_burst_ctl.sv
module rc_burst_ctl
  import rc_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_pend,
  input  logic [CW-1:0] fetch_len,
  input  logic          wb_pend,
  input  logic [CW-1:0] wb_len,
  input  logic          bus_ack,
  output logic          bus_req,
  output logic          bus_write,
  output logic [CW-1:0] bus_words,
  output logic          fetch_word,
  output logic          wb_word
);
  bus_state_e    state;
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= BUS_IDLE;
      remain    <= '0;
      bus_words <= '0;
    end else begin
      case (state)
        BUS_IDLE: begin
          if (wb_pend) begin
            state     <= BUS_WBACK;
            remain    <= wb_len;
            bus_words <= wb_len;
          end else if (fetch_pend) begin
            state     <= BUS_FETCH;
            remain    <= fetch_len;
            bus_words <= fetch_len;
          end
        end
        default: begin
          if (bus_ack) begin
            remain <= remain - CW'(1);
            if (remain == CW'(1)) state <= BUS_IDLE;
          end
        end
      endcase
    end
  end

  assign bus_req    = (state != BUS_IDLE);
  assign bus_write  = (state == BUS_WBACK);
  assign fetch_word = (state == BUS_FETCH) && bus_ack;
  assign wb_word    = (state == BUS_WBACK) && bus_ack;

  // R7: burst attributes hold until the last word
  assert_burst_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !(bus_ack && remain == CW'(1))) |=>
      bus_req && $stable(bus_write) && $stable(bus_words));
  assert_burst_end_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && remain == CW'(1)) |=> !bus_req);
  assert_wb_first_R6: assert property (@(posedge clk) disable iff (rst)
    (!bus_req && wb_pend) |=> bus_req && bus_write);
endmodule

// File: rtl/refcache_top.sv
module refcache_top #(
  parameter int REF_W = 32,
  parameter int LIMIT = 6,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             batch_en,
  input  logic             pop_req,
  output logic             pop_ready,
  output logic [REF_W-1:0] pop_ref,
  input  logic             push_req,
  input  logic [REF_W-1:0] push_ref,
  output logic             push_ready,
  output logic             bus_req,
  output logic             bus_write,
  output logic [CW-1:0]    bus_words,
  input  logic             bus_ack,
  input  logic [REF_W-1:0] bus_rd_data,
  output logic [REF_W-1:0] bus_wr_data
);
  logic [CW-1:0] free_cnt, wb_cnt, lim;
  logic          fetch_word, wb_word;

  assign lim        = batch_en ? CW'(LIMIT) : CW'(1);
  assign pop_ready  = (free_cnt != '0);
  assign push_ready = !(bus_req && bus_write) && (wb_cnt < lim);

  rc_fifo #(.W(REF_W), .DEPTH(LIMIT)) u_free (
    .clk(clk), .rst(rst),
    .wr_en(fetch_word), .wr_data(bus_rd_data),
    .rd_en(pop_req && pop_ready), .rd_data(pop_ref),
    .count(free_cnt)
  );

  rc_fifo #(.W(REF_W), .DEPTH(LIMIT)) u_done (
    .clk(clk), .rst(rst),
    .wr_en(push_req && push_ready), .wr_data(push_ref),
    .rd_en(wb_word), .rd_data(bus_wr_data),
    .count(wb_cnt)
  );

  rc_burst_ctl #(.CW(CW)) u_bus (
    .clk(clk), .rst(rst),
    .fetch_pend(free_cnt == '0), .fetch_len(lim),
    .wb_pend(wb_cnt >= lim), .wb_len(wb_cnt),
    .bus_ack(bus_ack),
    .bus_req(bus_req), .bus_write(bus_write), .bus_words(bus_words),
    .fetch_word(fetch_word), .wb_word(wb_word)
  );

  assert_fetch_on_empty_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && !bus_write) |-> $past(free_cnt) == '0);
  assert_wb_len_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && bus_write) |-> bus_words == $past(wb_cnt));
  assert_push_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_write) |-> !push_ready);
  assert_single_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && !$past(batch_en)) |-> bus_words == CW'(1));
endmodule

// File: tb/sim_refcache_top.sv
module sim_refcache_top;
  logic        clk = 0, rst = 1, batch_en = 1;
  logic        pop_req = 0, push_req = 0, bus_ack = 0;
  logic [31:0] push_ref = 0, bus_rd_data = 0;
  logic        pop_ready, push_ready, bus_req, bus_write;
  logic [31:0] pop_ref, bus_wr_data;
  logic [2:0]  bus_words;
  int checks = 0, fails = 0;
  logic [31:0] src = 32'h1000, pexp = 32'h1000, pushv = 32'h8000, wexp = 32'h8000;
  bit done = 0;

  always #5 clk = ~clk;

  refcache_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_req(input int lat, input string tag);
    int n = 0;
    while (!bus_req && n < 10) begin @(negedge clk); n++; end
    chk(n == lat, tag, n, lat);
  endtask

  task automatic serve_fetch(input int words, input string tag);
    chk(bus_req && !bus_write, tag, {bus_req, bus_write}, 2'b10);
    chk(bus_words == words, tag, bus_words, words);
    for (int i = 0; i < words; i++) begin
      chk(bus_req && !bus_write && bus_words == words, "R7", bus_words, words);
      bus_ack = 1; bus_rd_data = src; src++;
      @(negedge clk);
      bus_ack = 0;
    end
    chk(!bus_req, "R7", bus_req, 0);
  endtask

  task automatic serve_wb(input int words, input string tag);
    chk(bus_req && bus_write, tag, {bus_req, bus_write}, 2'b11);
    chk(bus_words == words, tag, bus_words, words);
    for (int i = 0; i < words; i++) begin
      chk(bus_wr_data == wexp, "R4", bus_wr_data, wexp);
      chk(!push_ready, "R5", push_ready, 0);
      chk(bus_req && bus_write && bus_words == words, "R7", bus_words, words);
      bus_ack = 1; wexp++;
      @(negedge clk);
      bus_ack = 0;
    end
    chk(!bus_req, "R7", bus_req, 0);
    chk(push_ready, "R5", push_ready, 1);
  endtask

  task automatic pop_one();
    chk(pop_ready, "R3", pop_ready, 1);
    chk(pop_ref == pexp, "R3", pop_ref, pexp);
    pop_req = 1; pexp++;
    @(negedge clk);
    pop_req = 0;
  endtask

  task automatic push_one();
    chk(push_ready, "R5", push_ready, 1);
    push_req = 1; push_ref = pushv; pushv++;
    @(negedge clk);
    push_req = 0;
  endtask

  task automatic pop_push();
    chk(pop_ready && push_ready, "R6", {pop_ready, push_ready}, 2'b11);
    chk(pop_ref == pexp, "R3", pop_ref, pexp);
    pop_req = 1; pexp++;
    push_req = 1; push_ref = pushv; pushv++;
    @(negedge clk);
    pop_req = 0; push_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_req, "R1", bus_req, 0);
    chk(!pop_ready, "R1", pop_ready, 0);
    chk(push_ready, "R1", push_ready, 1);
    rst = 0;
    wait_req(1, "R1");
    serve_fetch(6, "R2");
    repeat (2) begin
      @(negedge clk);
      chk(!bus_req, "R2", bus_req, 0);
    end
    // R6 sweep: both stores reach their trigger in the same cycle
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 5; i++) push_one();
      chk(!bus_req, "R4", bus_req, 0);
      for (int i = 0; i < 5; i++) pop_one();
      pop_push();
      chk(!push_ready, "R5", push_ready, 0);
      chk(!pop_ready, "R3", pop_ready, 0);
      @(negedge clk);
      chk(bus_req && bus_write, "R6", {bus_req, bus_write}, 2'b11);
      serve_wb(6, "R4");
      wait_req(1, "R6");
      serve_fetch(6, "R2");
    end
    // plain refill without a pending write-back
    for (int i = 0; i < 6; i++) pop_one();
    chk(!pop_ready, "R3", pop_ready, 0);
    wait_req(1, "R2");
    serve_fetch(6, "R2");
    // R8: single-reference mode
    batch_en = 0;
    @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      push_one();
      chk(!push_ready, "R8", push_ready, 0);
      wait_req(1, "R8");
      serve_wb(1, "R8");
    end
    for (int i = 0; i < 6; i++) pop_one();
    for (int r = 0; r < 3; r++) begin
      wait_req(1, "R8");
      serve_fetch(1, "R8");
      chk(pop_ready, "R8", pop_ready, 1);
      if (r < 2) pop_one();
    end
    pop_push();
    @(negedge clk);
    chk(bus_req && bus_write, "R6", {bus_req, bus_write}, 2'b11);
    serve_wb(1, "R8");
    wait_req(1, "R8");
    serve_fetch(1, "R8");
    // back to grouped mode
    batch_en = 1;
    @(negedge clk);
    pop_one();
    wait_req(1, "R2");
    serve_fetch(6, "R9");
    for (int i = 0; i < 6; i++) pop_one();
    wait_req(1, "R9");
    serve_fetch(6, "R9");
    finish_run();
  end
endmodule